// File: doc/BRIEF.md
# Video Palette and Screen Mode Register File

This block is a write-only control register file attached to an 8-bit I/O write port. A single port address carries four functions. The top two bits of the written byte choose the function, and the remaining bits carry its operand. One function moves a sticky pointer onto one of sixteen pens or onto the border entry. A second stores a 5-bit hardware colour code into whatever the pointer names. A third sets the screen mode and the two ROM-disable flags. The fourth sets the RAM configuration byte.

On the display side, the block turns a pen index and a display-enable flag into a colour code, one clock later. During non-display time the border entry is shown. A newly written screen mode waits in a pending register and only becomes active on the rising edge of horizontal sync, so the pen mask never changes in the middle of a line. Pixel unpacking and analogue colour generation sit outside this block.

Top module: `vid_palette_regs`

## Requirements
- R1: A write is accepted only when `io_wr` is 1 and `io_addr[15:8]` equals 0x7F. Any other write has no effect on any register or output.
- R2: Bits 7:6 of an accepted byte select the function: 00 pen pointer, 01 colour store, 10 mode and ROM control, 11 RAM configuration.
- R3: In a pointer write with bit 4 set, the border entry is selected and bits 3:0 are ignored. With bit 4 clear, bits 3:0 name the pen.
- R4: The pointer keeps its value until the next pointer write. Successive colour writes all land on the same entry.
- R5: A colour write stores bits 4:0 into the entry named by the pointer. Bit 5 is ignored.
- R6: Mode bits 1:0 are held pending and are copied to `mode_cur` only in the cycle where `hsync` is 1 and was 0 in the previous cycle. A level that stays high does not copy a later write.
- R7: A mode write in the same cycle as an HSYNC rising edge takes effect at that edge.
- R8: When `disp_en` is 0, `colour_out` shows the border entry.
- R9: When `disp_en` is 1, the pen index is masked by the active mode before lookup. Mode 0 uses `pen_idx[3:0]`, modes 1 and 3 use `pen_idx[1:0]`, and mode 2 uses `pen_idx[0]`.
- R10: `colour_out` is registered. It reflects the inputs and register contents present at the previous clock edge, so a colour write shows up one cycle after it is stored.
- R11: A mode/ROM write sets `rom_lo_off` from bit 2 and `rom_hi_off` from bit 3 at once, without waiting for HSYNC.
- R12: A RAM configuration write drives bits 5:0 onto `ram_cfg` at the next edge.
- R13: Reset clears all seventeen colour entries, the pointer (to pen 0), both mode registers, the ROM flags, `ram_cfg` and `colour_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 16 | I/O port address |
| io_data | input | 8 | I/O write data |
| hsync | input | 1 | Horizontal sync level |
| disp_en | input | 1 | 1 = active display, 0 = border |
| pen_idx | input | 4 | Pen index of the current pixel |
| colour_out | output | 5 | Registered hardware colour code |
| mode_cur | output | 2 | Active screen mode |
| rom_lo_off | output | 1 | Lower ROM disabled |
| rom_hi_off | output | 1 | Upper ROM disabled |
| ram_cfg | output | 6 | RAM bank and configuration |

## Verification
Two events can land on the same edge: a mode write can arrive exactly when HSYNC rises, and a colour write can hit the very pen being looked up. The bench creates the first collision directly, by raising `hsync` in the cycle that carries the mode write. It expects the new mode to be active one edge later, with the lookup that follows already using the new pen mask. The random phase toggles `hsync` and writes into pens under lookup freely. A bench model then judges every cycle on the rule that the output uses state from before the edge, while the mode transfer uses the pending value including any write made in that same cycle.

// File: rtl/vpr_pkg.sv
package vpr_pkg;
  localparam int PEN_W   = 4;
  localparam int COL_W   = 5;
  localparam int MODE_W  = 2;
  localparam int RAM_W   = 6;
  localparam int NUM_PENS = 1 << PEN_W;

  typedef enum logic [1:0] {
    FN_POINTER = 2'b00,
    FN_COLOUR  = 2'b01,
    FN_MODE    = 2'b10,
    FN_RAMCFG  = 2'b11
  } func_e;

  // Function code carried in the top two data bits.
  function automatic func_e func_of(input logic [7:0] d);
    return func_e'(d[7:6]);
  endfunction

  // Pen index mask for the active screen mode.
  function automatic logic [PEN_W-1:0] pen_mask(input logic [MODE_W-1:0] m);
    logic [PEN_W-1:0] r;
    case (m)
      2'd0:    r = {PEN_W{1'b1}};
      2'd2:    r = PEN_W'(1);
      default: r = PEN_W'(3);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/vpr_port_decode.sv
module vpr_port_decode
  import vpr_pkg::*;
#(
  parameter int          ADDR_W  = 16,
  parameter logic [7:0]  PORT_HI = 8'h7F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_data,
  output logic              ptr_wr,
  output logic              col_wr,
  output logic              mode_wr,
  output logic              ram_wr
);
  logic  port_hit;
  func_e fn;

  assign port_hit = io_wr && (io_addr[ADDR_W-1 -: 8] == PORT_HI);
  assign fn       = func_of(io_data);

  always_comb begin
    ptr_wr  = 1'b0;
    col_wr  = 1'b0;
    mode_wr = 1'b0;
    ram_wr  = 1'b0;
    if (port_hit) begin
      case (fn)
        FN_POINTER: ptr_wr  = 1'b1;
        FN_COLOUR:  col_wr  = 1'b1;
        FN_MODE:    mode_wr = 1'b1;
        default:    ram_wr  = 1'b1;
      endcase
    end
  end

  // R2: at most one function strobe per write
  assert_one_function_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ptr_wr, col_wr, mode_wr, ram_wr}));

  // R1: no strobe without a write to the matching port
  assert_port_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_wr || io_addr[ADDR_W-1 -: 8] != PORT_HI) |-> !(ptr_wr || col_wr || mode_wr || ram_wr));
endmodule

// File: rtl/vpr_palette_bank.sv
module vpr_palette_bank
  import vpr_pkg::*;
#(
  parameter int N_PENS = NUM_PENS
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ptr_wr,
  input  logic                          col_wr,
  input  logic [7:0]                    wr_data,
  output logic [N_PENS*COL_W-1:0]       pens_flat,
  output logic [COL_W-1:0]              border_col
);
  localparam int N_ENT = N_PENS + 1;
  localparam int ENT_W = $clog2(N_ENT);

  logic [ENT_W-1:0] ptr_q;
  logic [ENT_W-1:0] ptr_next;
  logic [COL_W-1:0] ent_q [N_ENT];

  // Bit 4 picks the border entry; otherwise bits 3:0 name the pen.
  assign ptr_next = wr_data[4] ? ENT_W'(N_PENS) : ENT_W'(wr_data[PEN_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_wr) ptr_q <= ptr_next;
  end

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    logic hit;
    assign hit = col_wr && (ptr_q == ENT_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)   ent_q[g] <= '0;
      else if (hit) ent_q[g] <= wr_data[COL_W-1:0];
    end
    if (g < N_PENS) begin : g_pen
      assign pens_flat[g*COL_W +: COL_W] = ent_q[g];
    end
  end

  assign border_col = ent_q[N_PENS];

  // R4: pointer only moves on a pointer write
  assert_ptr_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ptr_wr |=> ptr_q == $past(ptr_q));

  // R5: a colour write to the border lands in the border entry
  assert_border_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (col_wr && ptr_q == ENT_W'(N_PENS)) |=> border_col == $past(wr_data[COL_W-1:0]));
endmodule

// File: rtl/vpr_mode_ctrl.sv
module vpr_mode_ctrl
  import vpr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic              ram_wr,
  input  logic [7:0]        wr_data,
  input  logic              hsync,
  output logic [MODE_W-1:0] mode_cur,
  output logic              rom_lo_off,
  output logic              rom_hi_off,
  output logic [RAM_W-1:0]  ram_cfg
);
  logic              hs_q;
  logic              hs_rise;
  logic [MODE_W-1:0] mode_pend;
  logic [MODE_W-1:0] pend_eff;

  assign hs_rise  = hsync && !hs_q;
  // A write in the transfer cycle is forwarded straight to the active mode.
  assign pend_eff = mode_wr ? wr_data[MODE_W-1:0] : mode_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_q       <= 1'b0;
      mode_pend  <= '0;
      mode_cur   <= '0;
      rom_lo_off <= 1'b0;
      rom_hi_off <= 1'b0;
      ram_cfg    <= '0;
    end else begin
      hs_q <= hsync;
      if (mode_wr) begin
        mode_pend  <= wr_data[MODE_W-1:0];
        rom_lo_off <= wr_data[2];
        rom_hi_off <= wr_data[3];
      end
      if (hs_rise) mode_cur <= pend_eff;
      if (ram_wr)  ram_cfg  <= wr_data[RAM_W-1:0];
    end
  end

  // R6: active mode is frozen between HSYNC rising edges
  assert_mode_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_rise |=> mode_cur == $past(mode_cur));

  // R6: rising edge without a write copies the held value
  assert_mode_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_rise && !mode_wr) |=> mode_cur == $past(mode_pend));

  // R7: write coinciding with the edge is applied at once
  assert_mode_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_rise && mode_wr) |=> mode_cur == $past(wr_data[MODE_W-1:0]));

  // R11: ROM flags follow the write without waiting for sync
  assert_rom_now_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (rom_lo_off == $past(wr_data[2])) && (rom_hi_off == $past(wr_data[3])));
endmodule

// File: rtl/vpr_colour_lookup.sv
module vpr_colour_lookup
  import vpr_pkg::*;
#(
  parameter int N_PENS = NUM_PENS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    disp_en,
  input  logic [PEN_W-1:0]        pen_idx,
  input  logic [MODE_W-1:0]       mode_cur,
  input  logic [N_PENS*COL_W-1:0] pens_flat,
  input  logic [COL_W-1:0]        border_col,
  output logic [COL_W-1:0]        colour_out
);
  logic [PEN_W-1:0] idx_m;
  logic [COL_W-1:0] pen_col;
  logic [COL_W-1:0] sel_col;

  assign idx_m   = pen_idx & pen_mask(mode_cur);
  assign pen_col = pens_flat[idx_m*COL_W +: COL_W];
  assign sel_col = disp_en ? pen_col : border_col;

  always_ff @(posedge clk) begin
    if (!rst_n) colour_out <= '0;
    else        colour_out <= sel_col;
  end

  // R8: non-display time shows the border entry
  assert_border_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_en |=> colour_out == $past(border_col));

  // R9: in mode 2 only pens 0 and 1 can be reached
  assert_mode2_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_en && mode_cur == 2'd2) |=> colour_out == $past(pens_flat[pen_idx[0]*COL_W +: COL_W]));
endmodule

// File: rtl/vid_palette_regs.sv
module vid_palette_regs
  import vpr_pkg::*;
#(
  parameter int         ADDR_W  = 16,
  parameter logic [7:0] PORT_HI = 8'h7F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_data,
  input  logic              hsync,
  input  logic              disp_en,
  input  logic [PEN_W-1:0]  pen_idx,
  output logic [COL_W-1:0]  colour_out,
  output logic [MODE_W-1:0] mode_cur,
  output logic              rom_lo_off,
  output logic              rom_hi_off,
  output logic [RAM_W-1:0]  ram_cfg
);
  logic ptr_wr, col_wr, mode_wr, ram_wr;
  logic [NUM_PENS*COL_W-1:0] pens_flat;
  logic [COL_W-1:0]          border_col;

  vpr_port_decode #(.ADDR_W(ADDR_W), .PORT_HI(PORT_HI)) u_dec (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr), .io_data(io_data),
    .ptr_wr(ptr_wr), .col_wr(col_wr), .mode_wr(mode_wr), .ram_wr(ram_wr)
  );

  vpr_palette_bank #(.N_PENS(NUM_PENS)) u_pal (
    .clk(clk), .rst_n(rst_n), .ptr_wr(ptr_wr), .col_wr(col_wr), .wr_data(io_data),
    .pens_flat(pens_flat), .border_col(border_col)
  );

  vpr_mode_ctrl u_mode (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .ram_wr(ram_wr), .wr_data(io_data),
    .hsync(hsync), .mode_cur(mode_cur), .rom_lo_off(rom_lo_off),
    .rom_hi_off(rom_hi_off), .ram_cfg(ram_cfg)
  );

  vpr_colour_lookup #(.N_PENS(NUM_PENS)) u_look (
    .clk(clk), .rst_n(rst_n), .disp_en(disp_en), .pen_idx(pen_idx), .mode_cur(mode_cur),
    .pens_flat(pens_flat), .border_col(border_col), .colour_out(colour_out)
  );

  // R12: RAM configuration follows a RAM write
  assert_ram_cfg_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr |=> ram_cfg == $past(io_data[RAM_W-1:0]));
endmodule

// File: tb/test_vid_palette_regs.sv
module test_vid_palette_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_wr = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_data = '0;
  logic        hsync = 1'b0;
  logic        disp_en = 1'b0;
  logic [3:0]  pen_idx = '0;
  logic [4:0]  colour_out;
  logic [1:0]  mode_cur;
  logic        rom_lo_off, rom_hi_off;
  logic [5:0]  ram_cfg;

  int checks = 0;
  int fails  = 0;

  logic [4:0] m_pal [17];
  int         m_ptr;
  logic [1:0] m_pend, m_mode;
  logic       m_rlo, m_rhi, m_hs;
  logic [5:0] m_ram;

  always #2.5 clk = ~clk;

  vid_palette_regs i_vid_palette_regs (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr), .io_data(io_data),
    .hsync(hsync), .disp_en(disp_en), .pen_idx(pen_idx), .colour_out(colour_out),
    .mode_cur(mode_cur), .rom_lo_off(rom_lo_off), .rom_hi_off(rom_hi_off), .ram_cfg(ram_cfg)
  );

  function automatic int reach(input logic [1:0] m, input logic [3:0] i);
    if (m == 2'd0) return int'(i);
    if (m == 2'd2) return int'(i) % 2;
    return int'(i) % 4;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 17; k++) m_pal[k] = '0;
    m_ptr = 0; m_pend = '0; m_mode = '0; m_rlo = 0; m_rhi = 0; m_ram = '0; m_hs = 0;
  endtask

  // One clock: drive at negedge, model the edge, compare at the next negedge.
  task automatic step(input string tag, input logic wr, input logic [15:0] a,
                      input logic [7:0] d, input logic hs, input logic de, input logic [3:0] pi);
    logic [4:0] exp_col;
    @(negedge clk);
    io_wr = wr; io_addr = a; io_data = d; hsync = hs; disp_en = de; pen_idx = pi;
    exp_col = de ? m_pal[reach(m_mode, pi)] : m_pal[16];
    @(posedge clk);
    if (wr && a[15:8] == 8'h7F) begin
      case (d[7:6])
        2'b00: m_ptr = d[4] ? 16 : int'(d[3:0]);
        2'b01: m_pal[m_ptr] = d[4:0];
        2'b10: begin m_pend = d[1:0]; m_rlo = d[2]; m_rhi = d[3]; end
        default: m_ram = d[5:0];
      endcase
    end
    if (hs && !m_hs) m_mode = m_pend;
    m_hs = hs;
    @(negedge clk);
    chk(tag, "colour_out", int'(colour_out), int'(exp_col));
    chk(tag, "mode_cur", int'(mode_cur), int'(m_mode));
    chk(tag, "rom", int'({rom_hi_off, rom_lo_off}), int'({m_rhi, m_rlo}));
    chk(tag, "ram_cfg", int'(ram_cfg), int'(m_ram));
  endtask

  task automatic wr7f(input string tag, input logic [7:0] d);
    step(tag, 1'b1, 16'h7F00, d, 1'b0, 1'b1, 4'd0);
  endtask

  task automatic look(input string tag, input logic de, input logic [3:0] pi);
    step(tag, 1'b0, 16'h7F00, 8'h00, hsync, de, pi);
  endtask

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R13: everything reads zero after reset
    look("R13", 1'b0, 4'd0);
    look("R13", 1'b1, 4'd9);

    // R3 / R5: border store, bit 5 ignored, pen bits ignored under border select
    wr7f("R3", 8'b0001_0110);
    wr7f("R5", 8'b0110_1101);
    look("R8", 1'b0, 4'd6);
    look("R3", 1'b1, 4'd6);
    // R4: pointer sticky across two colour writes
    wr7f("R4", 8'h07);
    wr7f("R4", 8'h41);
    wr7f("R4", 8'h5A);
    look("R4", 1'b1, 4'd7);
    // R10: lookup of a pen in the cycle its colour is written sees the old value
    step("R10", 1'b1, 16'h7F00, 8'h43, 1'b0, 1'b1, 4'd7);
    look("R10", 1'b1, 4'd7);
    // R1: wrong port and missing strobe do nothing
    step("R1", 1'b1, 16'h7E00, 8'h5F, 1'b0, 1'b1, 4'd7);
    step("R1", 1'b0, 16'h7F00, 8'h5F, 1'b0, 1'b1, 4'd7);
    step("R1", 1'b1, 16'hFF00, 8'h8F, 1'b0, 1'b1, 4'd7);
    look("R1", 1'b1, 4'd7);
    // R11 / R6: ROM flags immediate, mode waits for HSYNC
    wr7f("R11", 8'b1000_1110);
    look("R6", 1'b1, 4'd7);
    step("R6", 1'b0, 16'h0, 8'h0, 1'b1, 1'b1, 4'd7);
    look("R9", 1'b1, 4'd7);
    // R6: level held high does not pass a later write
    step("R6", 1'b1, 16'h7F00, 8'h80, 1'b1, 1'b1, 4'd3);
    look("R6", 1'b1, 4'd3);
    step("R6", 1'b0, 16'h0, 8'h0, 1'b0, 1'b1, 4'd3);
    // R7: mode write on the HSYNC rising edge
    step("R7", 1'b1, 16'h7F00, 8'h81, 1'b1, 1'b1, 4'd7);
    look("R7", 1'b1, 4'd7);
    look("R9", 1'b1, 4'd6);
    step("R7", 1'b1, 16'h7F00, 8'h83, 1'b0, 1'b1, 4'd5);
    step("R7", 1'b1, 16'h7F00, 8'h80, 1'b1, 1'b1, 4'd5);
    look("R9", 1'b1, 4'd15);
    // R12: RAM configuration
    wr7f("R12", 8'hFD);
    wr7f("R12", 8'hC2);

    // R2: random mix of all functions, ports, sync and lookups
    for (int n = 0; n < 600; n++) begin
      logic [7:0] d;
      logic [15:0] a;
      d = 8'($urandom);
      a = ($urandom % 4 != 0) ? 16'h7F00 | 16'($urandom % 256) : 16'($urandom);
      step("R2", 1'($urandom % 3 != 0), a, d, 1'($urandom % 5 == 0),
           1'($urandom % 4 != 0), 4'($urandom));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule